// File: doc/BRIEF.md
# Single-Pin Mode and Sync Decoder

This block reads one control pin, already digitized and synchronized to the system clock, and turns its activity into an operating mode for a switching regulator controller. Out of reset the pin is read as a plain level: high asks for forced-PWM and low asks for auto mode. A short run of well-formed pulses moves the decoder into pulse control, and it stays there until reset. In pulse control the decoder reads four kinds of activity. A steady level selects auto or forced-PWM with spread spectrum on. A pair of pulses selects the same modes with spread spectrum off. A long run of clock pulses selects sync mode.

Pulses are qualified by counting system clock cycles. A pulse is accepted only when its high time and its rising-edge-to-rising-edge period both fall inside parameter windows. A quiet timer restarts on every pin edge. When it expires, the pulse train that preceded it is closed and a decision is taken.

Top module: `mode_sync_decoder`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (auto), `ss_en_o` is 1, `sync_lock_o` is 0 and `pulse_ctl_o` is 0. `mode_o` never takes the value 2'b11.
- R2: While `pulse_ctl_o` is 0, `mode_o` follows the pin one clock later: 2'b01 (forced-PWM) when the pin was high and 2'b00 when it was low. `ss_en_o` stays 1.
- R3: A pulse is valid when its high time lies in [HI_MIN, HI_MAX] cycles. When CHECK_PERIOD is set, its rise-to-rise period must also lie in [PER_MIN, PER_MAX]; the period is not checked for the first pulse of a train. `pulse_ctl_o` rises after the falling edge of the LOCK_PULSES-th consecutive valid pulse. Once set, `pulse_ctl_o` stays 1 until reset.
- R4: An invalid pulse restarts the count of consecutive valid pulses, so a train broken by one out-of-window pulse does not set `pulse_ctl_o`.
- R5: In pulse control, a pin held steady for TMODE_CYC cycles after a lone edge selects the mode by level, with `ss_en_o` set to 1. Before that time, the outputs do not change.
- R6: In pulse control, exactly two valid pulses followed by a steady level lasting TMODE_CYC cycles select the mode by the final level (high gives 2'b01, low gives 2'b00), with `ss_en_o` set to 0.
- R7: In pulse control, the falling edge of the SYNC_CYCLES-th consecutive valid pulse sets `mode_o` to 2'b10 and `sync_lock_o` to 1, and clears `ss_en_o`. One pulse fewer leaves sync mode unentered. `sync_lock_o` is 1 exactly when `mode_o` is 2'b10.
- R8: In sync mode, a pin held steady for TMODE_CYC cycles leaves sync. `mode_o` then follows the level, `ss_en_o` returns to 1, `sync_lock_o` clears and `pulse_ctl_o` stays 1.
- R9: In pulse control outside sync, a train of valid pulses whose count is neither 0 nor 2 and is below SYNC_CYCLES is discarded when the quiet timer expires. `mode_o` and `ss_en_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Synchronized control pin |
| mode_o | output | 2 | Mode code: 00 auto, 01 forced-PWM, 10 sync |
| ss_en_o | output | 1 | Spread-spectrum enable |
| sync_lock_o | output | 1 | Sync mode active |
| pulse_ctl_o | output | 1 | Pulse control active (sticky) |

## Verification
The internal state that can go wrong here is the valid-pulse run count and the quiet timer. Neither is visible directly. A run count that is off by one shows up late. `pulse_ctl_o` rises one pulse early or late, or `mode_o` reaches 2'b10 one pulse away from the 2048th fall. A double pulse can also be taken as a discarded train, which shows as a wrong `ss_en_o` only after the quiet timeout. A quiet timer that is wrong shows as a mode change before or well after TMODE_CYC cycles of steady pin. So the checks sample `mode_o` and `ss_en_o` both shortly before and well after each timeout.

// File: rtl/mss_pkg.sv
package mss_pkg;
   typedef enum logic [1:0] {
      MSS_AUTO = 2'b00,
      MSS_FPWM = 2'b01,
      MSS_SYNC = 2'b10
   } mss_mode_e;
endpackage

// File: rtl/mss_edge_timer.sv
module mss_edge_timer #(
   parameter int TMODE_CYC = 4096,
   parameter int CW        = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pin_i,
   output logic          rise_o,
   output logic          fall_o,
   output logic [CW-1:0] since_rise_o,
   output logic          steady_o
);
   localparam int           QW     = $clog2(TMODE_CYC + 1);
   localparam logic [QW-1:0] Q_FULL = QW'(TMODE_CYC);
   localparam logic [QW-1:0] Q_LAST = QW'(TMODE_CYC - 1);
   localparam logic [CW-1:0] R_SAT  = {CW{1'b1}};

   logic          pin_q;
   logic          edge_seen;
   logic [QW-1:0] quiet_q;
   logic [CW-1:0] since_q;

   assign rise_o    = pin_i & ~pin_q;
   assign fall_o    = ~pin_i & pin_q;
   assign edge_seen = rise_o | fall_o;
   assign steady_o  = !edge_seen && (quiet_q == Q_LAST);
   assign since_rise_o = since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q   <= 1'b0;
         quiet_q <= Q_FULL;
         since_q <= R_SAT;
      end else begin
         pin_q <= pin_i;
         if (edge_seen)
            quiet_q <= '0;
         else if (quiet_q != Q_FULL)
            quiet_q <= quiet_q + 1'b1;
         if (rise_o)
            since_q <= CW'(1);
         else if (since_q != R_SAT)
            since_q <= since_q + 1'b1;
      end
   end
endmodule

// File: rtl/mss_pulse_qualifier.sv
module mss_pulse_qualifier #(
   parameter int HI_MIN       = 20,
   parameter int HI_MAX       = 80,
   parameter int PER_MIN      = 50,
   parameter int PER_MAX      = 200,
   parameter bit CHECK_PERIOD = 1'b1,
   parameter int LOCK_PULSES  = 4,
   parameter int SYNC_CYCLES  = 2048,
   parameter int CW           = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise_i,
   input  logic          fall_i,
   input  logic          steady_i,
   input  logic [CW-1:0] since_rise_i,
   output logic          lock_hit_o,
   output logic          sync_hit_o,
   output logic          run_zero_o,
   output logic          run_two_o
);
   localparam int            RW     = $clog2(SYNC_CYCLES + 1);
   localparam logic [RW-1:0] R_TOP  = RW'(SYNC_CYCLES);
   localparam logic [RW-1:0] R_LOCK = RW'(LOCK_PULSES - 1);
   localparam logic [RW-1:0] R_SYNC = RW'(SYNC_CYCLES - 1);
   localparam logic [CW-1:0] H_LO   = CW'(HI_MIN);
   localparam logic [CW-1:0] H_HI   = CW'(HI_MAX);

   logic [RW-1:0] run_q;
   logic          per_ok_q;
   logic          per_fit;
   logic          hi_fit;
   logic          good;
   logic          bad;

   generate
      if (CHECK_PERIOD) begin : g_per_chk
         localparam logic [CW-1:0] P_LO = CW'(PER_MIN);
         localparam logic [CW-1:0] P_HI = CW'(PER_MAX);
         assign per_fit = (since_rise_i >= P_LO) && (since_rise_i <= P_HI);
      end else begin : g_per_free
         assign per_fit = 1'b1;
      end
   endgenerate

   assign hi_fit     = (since_rise_i >= H_LO) && (since_rise_i <= H_HI);
   assign good       = fall_i && per_ok_q && hi_fit;
   assign bad        = fall_i && !(per_ok_q && hi_fit);
   assign lock_hit_o = good && (run_q == R_LOCK);
   assign sync_hit_o = good && (run_q == R_SYNC);
   assign run_zero_o = (run_q == '0);
   assign run_two_o  = (run_q == RW'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= '0;
         per_ok_q <= 1'b0;
      end else begin
         if (rise_i)
            per_ok_q <= (run_q == '0) || per_fit;
         if (steady_i || bad)
            run_q <= '0;
         else if (good && run_q != R_TOP)
            run_q <= run_q + 1'b1;
      end
   end
endmodule

// File: rtl/mss_mode_ctrl.sv
module mss_mode_ctrl
   import mss_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin_i,
   input  logic      steady_i,
   input  logic      lock_hit_i,
   input  logic      sync_hit_i,
   input  logic      run_zero_i,
   input  logic      run_two_i,
   output mss_mode_e mode_o,
   output logic      ss_en_o,
   output logic      pulse_ctl_o
);
   mss_mode_e lvl_mode;
   assign lvl_mode = pin_i ? MSS_FPWM : MSS_AUTO;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o      <= MSS_AUTO;
         ss_en_o     <= 1'b1;
         pulse_ctl_o <= 1'b0;
      end else begin
         if (lock_hit_i)
            pulse_ctl_o <= 1'b1;
         if (!pulse_ctl_o) begin
            mode_o  <= lvl_mode;
            ss_en_o <= 1'b1;
         end else if (sync_hit_i) begin
            mode_o  <= MSS_SYNC;
            ss_en_o <= 1'b0;
         end else if (steady_i) begin
            if (mode_o == MSS_SYNC || run_zero_i) begin
               mode_o  <= lvl_mode;
               ss_en_o <= 1'b1;
            end else if (run_two_i) begin
               mode_o  <= lvl_mode;
               ss_en_o <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/mode_sync_decoder.sv
module mode_sync_decoder
   import mss_pkg::*;
#(
   parameter int HI_MIN       = 20,
   parameter int HI_MAX       = 80,
   parameter int PER_MIN      = 50,
   parameter int PER_MAX      = 200,
   parameter bit CHECK_PERIOD = 1'b1,
   parameter int LOCK_PULSES  = 4,
   parameter int SYNC_CYCLES  = 2048,
   parameter int TMODE_CYC    = 4096
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   output logic [1:0] mode_o,
   output logic       ss_en_o,
   output logic       sync_lock_o,
   output logic       pulse_ctl_o
);
   localparam int CW = $clog2(PER_MAX + 2);

   generate
      if (HI_MIN < 1 || HI_MIN > HI_MAX)
         $error("high-time window is empty");
      if (PER_MIN <= HI_MIN || PER_MIN > PER_MAX)
         $error("period window is empty or shorter than high time");
      if (LOCK_PULSES <= 2 || SYNC_CYCLES <= LOCK_PULSES)
         $error("lock count must exceed 2 and stay below sync count");
      if (TMODE_CYC <= PER_MAX)
         $error("quiet timeout must exceed the longest period");
   endgenerate

   logic          rise, fall, steady;
   logic [CW-1:0] since_rise;
   logic          lock_hit, sync_hit, run_zero, run_two;
   mss_mode_e     mode_e;

   mss_edge_timer #(.TMODE_CYC(TMODE_CYC), .CW(CW)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .pin_i        (pin_i),
      .rise_o       (rise),
      .fall_o       (fall),
      .since_rise_o (since_rise),
      .steady_o     (steady)
   );

   mss_pulse_qualifier #(
      .HI_MIN(HI_MIN), .HI_MAX(HI_MAX), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
      .CHECK_PERIOD(CHECK_PERIOD), .LOCK_PULSES(LOCK_PULSES),
      .SYNC_CYCLES(SYNC_CYCLES), .CW(CW)
   ) u_qual (
      .clk          (clk),
      .rst_n        (rst_n),
      .rise_i       (rise),
      .fall_i       (fall),
      .steady_i     (steady),
      .since_rise_i (since_rise),
      .lock_hit_o   (lock_hit),
      .sync_hit_o   (sync_hit),
      .run_zero_o   (run_zero),
      .run_two_o    (run_two)
   );

   mss_mode_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pin_i),
      .steady_i    (steady),
      .lock_hit_i  (lock_hit),
      .sync_hit_i  (sync_hit),
      .run_zero_i  (run_zero),
      .run_two_i   (run_two),
      .mode_o      (mode_e),
      .ss_en_o     (ss_en_o),
      .pulse_ctl_o (pulse_ctl_o)
   );

   assign mode_o      = mode_e;
   assign sync_lock_o = (mode_e == MSS_SYNC);
endmodule

// File: rtl/mode_sync_decoder_chk.sv
module mode_sync_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pin_i,
   input logic [1:0] mode_o,
   input logic       ss_en_o,
   input logic       sync_lock_o,
   input logic       pulse_ctl_o
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o != 2'b11);

   p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !pulse_ctl_o) |-> (mode_o == ($past(pin_i) ? 2'b01 : 2'b00)));

   p_level_ss_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_ctl_o |-> ss_en_o);

   p_sticky_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_ctl_o |=> pulse_ctl_o);

   p_sync_ss_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lock_o |-> (!ss_en_o && pulse_ctl_o));

   p_sync_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_lock_o) |-> $past(!pin_i) == 1'b1);
endmodule

bind mode_sync_decoder mode_sync_decoder_chk u_chk (.*);

// File: tb/mode_sync_decoder_bench.sv
module mode_sync_decoder_bench;
   localparam int HI_MIN = 2, HI_MAX = 6, PER_MIN = 6, PER_MAX = 12;
   localparam int LOCK = 4, SYNC_N = 2048, TMODE = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin = 1'b0;
   logic [1:0] mode;
   logic       ss_en, sync_lock, pulse_ctl;
   int         n_run = 0;
   int         n_fail = 0;

   always #4 clk = ~clk;

   mode_sync_decoder #(
      .HI_MIN(HI_MIN), .HI_MAX(HI_MAX), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
      .CHECK_PERIOD(1'b1), .LOCK_PULSES(LOCK), .SYNC_CYCLES(SYNC_N),
      .TMODE_CYC(TMODE)
   ) u_mode_sync_decoder (
      .clk(clk), .rst_n(rst_n), .pin_i(pin),
      .mode_o(mode), .ss_en_o(ss_en), .sync_lock_o(sync_lock),
      .pulse_ctl_o(pulse_ctl)
   );

   task automatic expect_out(string tag, logic [1:0] m, logic s, logic k, logic p);
      n_run++;
      if (mode !== m || ss_en !== s || sync_lock !== k || pulse_ctl !== p) begin
         n_fail++;
         $display("FAIL %s: got mode=%b ss=%b lock=%b pctl=%b, expected mode=%b ss=%b lock=%b pctl=%b",
                  tag, mode, ss_en, sync_lock, pulse_ctl, m, s, k, p);
      end
   endtask

   task automatic hold(logic lvl, int n);
      pin = lvl;
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(int hi, int per);
      hold(1'b1, hi);
      hold(1'b0, per - hi);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pin   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset_r1();
      do_reset();
      expect_out("R1 reset state", 2'b00, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_level_r2();
      do_reset();
      hold(1'b1, 3);
      expect_out("R2 level high", 2'b01, 1'b1, 1'b0, 1'b0);
      hold(1'b0, 3);
      expect_out("R2 level low", 2'b00, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_lock_r3_r5_r9_r6();
      do_reset();
      for (int i = 0; i < LOCK - 1; i++) pulse(3, 8);
      hold(1'b0, TMODE + 16);
      expect_out("R3 three pulses no lock", 2'b00, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < LOCK; i++) pulse(3, 8);
      expect_out("R3 lock on fourth pulse", 2'b00, 1'b1, 1'b0, 1'b1);
      hold(1'b0, TMODE + 16);
      expect_out("R3 lock is sticky", 2'b00, 1'b1, 1'b0, 1'b1);
      hold(1'b1, TMODE - 20);
      expect_out("R5 no change before timeout", 2'b00, 1'b1, 1'b0, 1'b1);
      hold(1'b1, 40);
      expect_out("R5 steady high gives fpwm", 2'b01, 1'b1, 1'b0, 1'b1);
      // R9: three valid pulses then quiet: discarded, fpwm kept while pin low
      hold(1'b0, 5);
      for (int i = 0; i < 3; i++) pulse(3, 8);
      hold(1'b0, TMODE + 16);
      expect_out("R9 three-pulse train discarded", 2'b01, 1'b1, 1'b0, 1'b1);
      // R6: double pulse settling low, then double pulse settling high
      pulse(3, 8); pulse(3, 8);
      hold(1'b0, TMODE + 16);
      expect_out("R6 double pulse low", 2'b00, 1'b0, 1'b0, 1'b1);
      pulse(3, 8); pulse(3, 8);
      hold(1'b1, TMODE + 16);
      expect_out("R6 double pulse high", 2'b01, 1'b0, 1'b0, 1'b1);
      hold(1'b0, TMODE + 16);
      expect_out("R5 plain low restores spread", 2'b00, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_invalid_r4();
      do_reset();
      pulse(3, 8); pulse(3, 8); pulse(3, 20);
      pulse(3, 8); pulse(3, 8); pulse(3, 8);
      hold(1'b0, TMODE + 16);
      expect_out("R4 long period breaks train", 2'b00, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) pulse(3, 8);
      pulse(10, 16);
      pulse(3, 8);
      hold(1'b0, TMODE + 16);
      expect_out("R4 wide pulse breaks train", 2'b00, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_sync_r7_r8();
      do_reset();
      for (int i = 0; i < SYNC_N - 1; i++) pulse(3, 8);
      expect_out("R7 one pulse short of sync", 2'b00, 1'b1, 1'b0, 1'b1);
      pulse(3, 8);
      expect_out("R7 sync entered", 2'b10, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 5; i++) pulse(3, 8);
      hold(1'b1, TMODE - 20);
      expect_out("R8 sync held before timeout", 2'b10, 1'b0, 1'b1, 1'b1);
      hold(1'b1, 40);
      expect_out("R8 sync exit to fpwm", 2'b01, 1'b1, 1'b0, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset_r1();
      t_level_r2();
      t_lock_r3_r5_r9_r6();
      t_invalid_r4();
      t_sync_r7_r8();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule